// File: doc/BRIEF.md
# Legacy Parallel Port Register Block

This block is the processor-facing register set of a PC-style parallel printer port. It sits on a small synchronous byte bus and answers three consecutive byte addresses that start at a base address fixed by a parameter. The base address holds an 8-bit data latch that drives the eight data pins of the connector. The next address is a read-only window onto five live status pins. The address after that holds a 5-bit control latch. Four of its bits drive connector control pins, three of them inverted, and the fifth bit enables the interrupt.

Reads of the data and control addresses do not return the latches directly. They return the levels on the pins, where the latch output is wired-ORed with any level an outside device drives. Control bits are mapped back through the same inversions. The block also watches the acknowledge pin (connector pin 10). It passes that pin through a two-flop synchronizer. When the interrupt enable is set, each falling edge of the pin produces an interrupt pulse one clock long. The edge detector is a three-state machine: `ACK_HIGH` (synchronized pin high, armed), `ACK_FIRE` (edge seen, interrupt pulse) and `ACK_LOW` (pin low, waiting). Its transitions are:
- `ACK_HIGH`→`ACK_FIRE` when the pin is low and the enable is 1.
- `ACK_HIGH`→`ACK_LOW` when the pin is low and the enable is 0.
- `ACK_FIRE`→`ACK_LOW` when the pin is still low.
- `ACK_FIRE`→`ACK_HIGH` when the pin is high again.
- `ACK_LOW`→`ACK_HIGH` when the pin rises.

Top module: `pport_regs`

## Requirements
- R1: Only addresses BASE (data), BASE+1 (status) and BASE+2 (control) are decoded; BASE is one of 0x278, 0x378, 0x3BC (default 0x378). A write to any other address changes nothing, and a read of any other address returns 0x00.
- R2: A write to BASE stores all 8 bits; `data_pin_out[i]` (connector pin 2+i) equals bit i of the written byte from the clock edge that takes the write.
- R3: A write to BASE+2 stores bits 4..0 and ignores bits 7..5. `ctl_pin_out` is {pin17, pin16, pin14, pin1} = {~b3, b2, ~b1, ~b0}.
- R4: A read of BASE returns `data_pin_out | data_pin_ext`.
- R5: A read of BASE+1 returns the live pins: bit7=`status_pins[4]` (pin 11), bit6=`status_pins[3]` (pin 10), bit5=`status_pins[2]` (pin 12), bit4=`status_pins[1]` (pin 13), bit3=`status_pins[0]` (pin 15), bits 2..0 = 0.
- R6: A read of BASE+2 returns bits 7..5 = 0 and bit4 = the enable. With level L = `ctl_pin_out | ctl_pin_ext`, bits 3..0 are {~L[3], L[2], ~L[1], ~L[0]}. With no external drive this equals bits 4..0 last written.
- R7: After reset the data latch is 0x00 and control bits 4..0 are 0,1,0,1,1 (0x0B), so `ctl_pin_out` = 4'b0000. `bus_rdata` = 0x00 and `irq` = 0.
- R8: Suppose `status_pins[3]` falls between two clock edges and the enable is 1 when the synchronized level first shows low. Then `irq` is high for exactly one cycle, after the third edge following the change. Each fall gives one pulse. With the enable at 0, no pulse is given.
- R9: A write to BASE+1 has no effect on the data or control latches.
- R10: `bus_rdata` is loaded on the edge that samples `bus_rd` and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| data_pin_out | output | 8 | Levels driven onto connector pins 2..9 |
| data_pin_ext | input | 8 | External drive on pins 2..9 (1 = pulled high) |
| ctl_pin_out | output | 4 | Driven levels of pins {17,16,14,1} |
| ctl_pin_ext | input | 4 | External drive on pins {17,16,14,1} |
| status_pins | input | 5 | Pins {11,10,12,13,15} |
| irq | output | 1 | Interrupt pulse |

## Verification
The pin outputs change on the first edge after a write strobe. `bus_rdata` changes on the first edge after a read strobe. `irq` rises three edges after the acknowledge pin changes. The bench drives inputs on the falling edge and samples results on the next falling edge. For `irq`, it counts falling edges from the pin change and expects the pulse at the third and not at the second or fourth. A behavioural model that keeps the same edge count is compared with every output on every falling edge.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int DATA_W = 8;
    localparam int CTL_W  = 5;
    localparam logic [CTL_W-1:0] CTL_RESET = 5'b01011;
    localparam logic [3:0]       CTL_INV   = 4'b1011;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_STAT,
        SEL_CTL
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACK_HIGH,
        ACK_FIRE,
        ACK_LOW
    } ack_state_e;
endpackage

// File: rtl/pport_decode.sv
module pport_decode
    import pport_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BASE   = 'h378
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE + 1);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(BASE + 2);

    always_comb begin
        if (addr == A_DATA)      sel = SEL_DATA;
        else if (addr == A_STAT) sel = SEL_STAT;
        else if (addr == A_CTL)  sel = SEL_CTL;
        else                     sel = SEL_NONE;
    end
endmodule

// File: rtl/pport_latches.sv
module pport_latches
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] data_q,
    output logic [CTL_W-1:0]  ctl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            ctl_q  <= CTL_RESET;
        end else if (wr) begin
            if (sel == SEL_DATA) data_q <= wdata;
            if (sel == SEL_CTL)  ctl_q  <= wdata[CTL_W-1:0];
        end
    end
endmodule

// File: rtl/pport_ack_irq.sv
module pport_ack_irq
    import pport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_pin,
    input  logic enable,
    output logic irq
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ack_lvl;
    ack_state_e             state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ack_pin};
    end
    assign ack_lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACK_HIGH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_HIGH: if (!ack_lvl) state_d = enable ? ACK_FIRE : ACK_LOW;
            ACK_FIRE: state_d = ack_lvl ? ACK_HIGH : ACK_LOW;
            ACK_LOW:  if (ack_lvl) state_d = ACK_HIGH;
            default:  state_d = ACK_HIGH;
        endcase
    end

    always_comb begin
        irq = (state_q == ACK_FIRE);
    end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int BASE        = 'h378,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic [7:0]        data_pin_out,
    input  logic [7:0]        data_pin_ext,
    output logic [3:0]        ctl_pin_out,
    input  logic [3:0]        ctl_pin_ext,
    input  logic [4:0]        status_pins,
    output logic              irq
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] data_q;
    logic [CTL_W-1:0]  ctl_q;
    logic              irq_en;
    logic [3:0]        ctl_lvl;
    logic [3:0]        ctl_rb;
    logic [7:0]        rdata_q;

    pport_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    pport_latches u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .sel    (sel),
        .wdata  (bus_wdata),
        .data_q (data_q),
        .ctl_q  (ctl_q)
    );

    assign irq_en       = ctl_q[4];
    assign data_pin_out = data_q;
    assign ctl_lvl      = ctl_pin_out | ctl_pin_ext;

    for (genvar i = 0; i < 4; i++) begin : g_ctl_map
        if (CTL_INV[i]) begin : g_inv
            assign ctl_pin_out[i] = ~ctl_q[i];
            assign ctl_rb[i]      = ~ctl_lvl[i];
        end else begin : g_pass
            assign ctl_pin_out[i] = ctl_q[i];
            assign ctl_rb[i]      = ctl_lvl[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            unique case (sel)
                SEL_DATA: rdata_q <= data_q | data_pin_ext;
                SEL_STAT: rdata_q <= {status_pins, 3'b000};
                SEL_CTL:  rdata_q <= {3'b000, irq_en, ctl_rb};
                default:  rdata_q <= '0;
            endcase
        end
    end
    assign bus_rdata = rdata_q;

    pport_ack_irq #(.SYNC_STAGES(SYNC_STAGES)) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_pin (status_pins[3]),
        .enable  (irq_en),
        .irq     (irq)
    );
endmodule

// File: rtl/pport_regs_chk.sv
module pport_regs_chk #(
    parameter int ADDR_W = 10,
    parameter int BASE   = 'h378
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic [7:0]        data_pin_out,
    input logic [7:0]        data_pin_ext,
    input logic [3:0]        ctl_pin_out,
    input logic [4:0]        status_pins,
    input logic              irq,
    input logic              irq_en
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE + 1);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(BASE + 2);

    assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DATA) |=> data_pin_out == $past(bus_wdata));

    assert_ctl_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTL) |=>
        ctl_pin_out == {~$past(bus_wdata[3]), $past(bus_wdata[2]),
                        ~$past(bus_wdata[1]), ~$past(bus_wdata[0])});

    assert_data_read_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_DATA) |=>
        bus_rdata == ($past(data_pin_out) | $past(data_pin_ext)));

    assert_status_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STAT) |=> bus_rdata == {$past(status_pins), 3'b000});

    assert_ctl_read_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_CTL) |=> bus_rdata[7:5] == 3'b000);

    assert_irq_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en));

    assert_stat_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STAT) |=> $stable(data_pin_out) && $stable(ctl_pin_out));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind pport_regs pport_regs_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .data_pin_out (data_pin_out),
    .data_pin_ext (data_pin_ext),
    .ctl_pin_out  (ctl_pin_out),
    .status_pins  (status_pins),
    .irq          (irq),
    .irq_en       (irq_en)
);

// File: tb/tb_pport_regs.sv
`timescale 1ns/1ps
module tb_pport_regs;
    localparam int BASE = 'h378;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] data_pin_out;
    logic [7:0] data_pin_ext = '0;
    logic [3:0] ctl_pin_out;
    logic [3:0] ctl_pin_ext = '0;
    logic [4:0] status_pins = 5'b11111;
    logic       irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pport_regs #(.BASE(BASE)) dut (.*);

    // behavioural reference state
    logic [7:0] m_data, m_rd;
    logic [4:0] m_ctl;
    logic       m_irq;
    logic       m_s1, m_s2, m_s3;

    function automatic logic [3:0] pins_of(input logic [4:0] c);
        return {~c[3], c[2], ~c[1], ~c[0]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_data = 8'h00; m_ctl = 5'h0B; m_rd = 8'h00; m_irq = 1'b0;
            m_s1 = 1'b1; m_s2 = 1'b1; m_s3 = 1'b1;
        end else begin
            logic [3:0] lvl;
            lvl = pins_of(m_ctl) | ctl_pin_ext;
            if (bus_rd) begin
                if (bus_addr == 10'(BASE))          m_rd = m_data | data_pin_ext;
                else if (bus_addr == 10'(BASE + 1)) m_rd = {status_pins, 3'b000};
                else if (bus_addr == 10'(BASE + 2)) m_rd = {3'b000, m_ctl[4], ~lvl[3], lvl[2], ~lvl[1], ~lvl[0]};
                else                                m_rd = 8'h00;
            end
            m_irq = m_ctl[4] && m_s3 && !m_s2;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = status_pins[3];
            if (bus_wr && bus_addr == 10'(BASE))     m_data = bus_wdata;
            if (bus_wr && bus_addr == 10'(BASE + 2)) m_ctl = bus_wdata[4:0];
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R2 model data pins", data_pin_out, m_data);
            chk("R3 model ctl pins", {4'h0, ctl_pin_out}, {4'h0, pins_of(m_ctl)});
            chk("R10 model rdata", bus_rdata, m_rd);
            chk("R8 model irq", {7'h0, irq}, {7'h0, m_irq});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = 10'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input string tag, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = 10'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk("R7 data pins reset", data_pin_out, 8'h00);
        chk("R7 ctl pins reset", {4'h0, ctl_pin_out}, 8'h00);
        chk("R7 rdata reset", bus_rdata, 8'h00);
        chk("R7 irq reset", {7'h0, irq}, 8'h00);
        rd(BASE + 2, "R7 ctl readback reset", 8'h0B);
        rd(BASE, "R7 data readback reset", 8'h00);

        // R2 / R4 data path
        wr(BASE, 8'hA5);
        chk("R2 data pins", data_pin_out, 8'hA5);
        rd(BASE, "R4 data read no drive", 8'hA5);
        data_pin_ext = 8'h18;
        rd(BASE, "R4 data read wired-or", 8'hBD);
        data_pin_ext = 8'h00;

        // R3 / R6 control path
        wr(BASE + 2, 8'hE6);
        chk("R3 ctl pins inverted map", {4'h0, ctl_pin_out}, 8'h0D);
        rd(BASE + 2, "R6 ctl read top bits dropped", 8'h06);
        ctl_pin_ext = 4'b0010;
        rd(BASE + 2, "R6 ctl read external pin14", 8'h04);
        ctl_pin_ext = 4'b0000;

        // R5 status
        status_pins = 5'b10110;
        rd(BASE + 1, "R5 status read a", 8'hB0);
        status_pins = 5'b01001;
        rd(BASE + 1, "R5 status read b", 8'h48);
        status_pins = 5'b11111;

        // R9 status address write
        wr(BASE + 1, 8'hFF);
        chk("R9 data unchanged", data_pin_out, 8'hA5);
        chk("R9 ctl unchanged", {4'h0, ctl_pin_out}, 8'h0D);

        // R1 foreign addresses
        wr('h278, 8'h3C);
        wr('h37B, 8'h1F);
        chk("R1 data unchanged", data_pin_out, 8'hA5);
        chk("R1 ctl unchanged", {4'h0, ctl_pin_out}, 8'h0D);
        rd('h2F8, "R1 foreign read", 8'h00);

        // R10 hold
        rd(BASE, "R10 read before hold", 8'hA5);
        data_pin_ext = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R10 rdata held", bus_rdata, 8'hA5);
        data_pin_ext = 8'h00;

        // R8 disabled: no pulse
        status_pins[3] = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R8 no irq when disabled", {7'h0, irq}, 8'h00);
        end
        status_pins[3] = 1'b1;
        repeat (4) @(negedge clk);

        // R8 enabled
        wr(BASE + 2, 8'h10);
        chk("R3 ctl pins enable only", {4'h0, ctl_pin_out}, 8'h0B);
        rd(BASE + 2, "R6 enable readback", 8'h10);
        for (int n = 0; n < 2; n++) begin
            status_pins[3] = 1'b0;
            @(negedge clk); chk("R8 edge+1 low", {7'h0, irq}, 8'h00);
            @(negedge clk); chk("R8 edge+2 low", {7'h0, irq}, 8'h00);
            @(negedge clk); chk("R8 edge+3 pulse", {7'h0, irq}, 8'h01);
            @(negedge clk); chk("R8 edge+4 low", {7'h0, irq}, 8'h00);
            repeat (4) begin
                @(negedge clk); chk("R8 no repeat while low", {7'h0, irq}, 8'h00);
            end
            status_pins[3] = 1'b1;
            repeat (4) @(negedge clk);
        end

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule